// File: doc/BRIEF.md
# Non-Blocking Load Miss Tracker

This block lets an in-order pipeline keep issuing instructions after a load misses in the data cache. It keeps a small table of missing memory lines that are still on their way from memory. Each table slot holds one line address, and for each word of that line it holds at most one destination register that is waiting for that word. When a second load misses on a line that is already outstanding, it joins the existing slot, so memory is not asked for the same line twice. A new line gets a fresh slot and a memory request, which is tagged with that slot's index.

Alongside the table, the block keeps a full/empty bit for every architectural register. An accepted load miss marks its destination Empty, so the load can retire from the pipeline at once. Decode asks through the query port whether a source register is Full and holds the instruction while it is not. When memory returns a line with its tag, the block sends every waiting word to its register over a multi-lane writeback port. In the same cycle it marks those registers Full and releases the slot.

Top module: `mshr_unit`

## Requirements
- R1: After reset no slot is in use, every register reads Full on the query port, and no memory request or writeback lane is active.
- R2: An accepted miss to a line that no slot tracks raises memReqValid in the same cycle, with memReqLine equal to the miss line and memReqTag equal to the lowest-numbered idle slot.
- R3: An accepted miss to a line that a slot already tracks, on a word of that line with no waiter, joins that slot, does not stall and raises no memory request.
- R4: From the cycle after a miss is accepted, its destination register reads Empty (qryFull = 0).
- R5: In a cycle with refillValid for a busy slot, writeback lane w is valid exactly when word w of that slot has a waiter; its wbDest is that waiter and its wbData is word w of refillData, taken from bits [w*DATA_W +: DATA_W].
- R6: The cycle after a refill, every register it wrote reads Full and the slot is idle, so a new miss to that line allocates again.
- R7: When all slots are busy and a miss targets an untracked line, missStall is high, no request is issued and the destination stays Full.
- R8: A miss to a word that already has a waiter in its tracked line is stalled and leaves its destination Full.
- R9: A miss whose destination register already reads Empty is stalled.
- R10: A miss presented in the same cycle as refillValid is stalled and issues no request.
- R11: A refill whose tag names an idle slot produces no writeback lane and changes no register state.
- R12: Up to NUM_SLOTS lines can be outstanding at once, each carrying a distinct request tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | A load miss is presented |
| missLine | input | LINE_W | Line address of the missing load |
| missWord | input | $clog2(WORDS) | Word within the line |
| missDest | input | REG_W | Destination register of the load |
| missStall | output | 1 | Miss cannot be accepted this cycle |
| memReqValid | output | 1 | Line fetch request to memory |
| memReqLine | output | LINE_W | Line address to fetch |
| memReqTag | output | $clog2(NUM_SLOTS) | Slot index carried with the request |
| refillValid | input | 1 | Memory returns a line |
| refillTag | input | $clog2(NUM_SLOTS) | Tag of the returning line |
| refillData | input | WORDS*DATA_W | Whole line, word w at bits [w*DATA_W +: DATA_W] |
| wbValid | output | WORDS | Per-lane register write enable |
| wbDest | output | WORDS*REG_W | Per-lane destination register |
| wbData | output | WORDS*DATA_W | Per-lane write data |
| qryReg | input | REG_W | Register that decode asks about |
| qryFull | output | 1 | Queried register holds valid data |

## Verification
The assertions check on every cycle that a new slot is only taken when it is idle and never while all slots are busy, that nothing is accepted during a refill, that every writeback lane targets a register marked Empty, and that an accepted destination reads Empty one cycle later. Only the bench's scenarios show the externally visible results: lowest-free tag choice, merging without a second request, the three stall causes leaving the scoreboard untouched, the data placed on each writeback lane, and a released slot being reused.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  // Per-cycle commands from control to the slot datapath.
  typedef struct packed {
    logic alloc;  // open a new slot at allocIdx
    logic merge;  // add a waiter to slot mergeIdx
    logic free;   // refill: write back and release slot freeIdx
  } mshrStrobes_t;
endpackage

// File: rtl/mshr_ctrl.sv
module mshr_ctrl
  import mshr_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int WORDS     = 4,
  parameter int LINE_W    = 28,
  parameter int REG_W     = 5,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int WOFF_W   = $clog2(WORDS),
  localparam int NUM_REGS = 1 << REG_W
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              missValid,
  input  logic [LINE_W-1:0]                 missLine,
  input  logic [WOFF_W-1:0]                 missWord,
  input  logic [REG_W-1:0]                  missDest,
  input  logic                              refillValid,
  input  logic [IDX_W-1:0]                  refillTag,
  input  logic [NUM_SLOTS-1:0]              entValid,
  input  logic [NUM_SLOTS-1:0][LINE_W-1:0]  entLine,
  input  logic [NUM_SLOTS-1:0][WORDS-1:0]   slotBusy,
  input  logic [NUM_REGS-1:0]               regEmpty,
  output mshrStrobes_t                      strb,
  output logic [IDX_W-1:0]                  allocIdx,
  output logic [IDX_W-1:0]                  mergeIdx,
  output logic [IDX_W-1:0]                  freeIdx,
  output logic                              missStall,
  output logic                              memReqValid,
  output logic [LINE_W-1:0]                 memReqLine,
  output logic [IDX_W-1:0]                  memReqTag
);
  logic             hitAny, idleAny, blocked, accept;
  logic [IDX_W-1:0] hitIdx, idleIdx;

  // Descending scan so the lowest matching / idle index wins.
  always_comb begin
    hitAny  = 1'b0;
    hitIdx  = '0;
    idleAny = 1'b0;
    idleIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (entValid[i] && (entLine[i] == missLine)) begin
        hitAny = 1'b1;
        hitIdx = IDX_W'(i);
      end
      if (!entValid[i]) begin
        idleAny = 1'b1;
        idleIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    blocked = refillValid                          // refill owns the cycle
           || regEmpty[missDest]                   // destination already pending
           || (hitAny && slotBusy[hitIdx][missWord]) // word slot taken
           || (!hitAny && !idleAny);               // table full
    accept      = missValid && !blocked;
    missStall   = missValid && blocked;
    strb.alloc  = accept && !hitAny;
    strb.merge  = accept && hitAny;
    strb.free   = refillValid && entValid[refillTag];
    allocIdx    = idleIdx;
    mergeIdx    = hitIdx;
    freeIdx     = refillTag;
    memReqValid = strb.alloc;
    memReqLine  = missLine;
    memReqTag   = idleIdx;
  end

  // R10: nothing is taken into the table during a refill cycle.
  a_r10_no_accept_on_refill: assert property (@(posedge clk) disable iff (!rstN)
    refillValid |-> !strb.alloc && !strb.merge);

  // R3: joining an existing slot never fetches the line again.
  a_r3_merge_no_request: assert property (@(posedge clk) disable iff (!rstN)
    strb.merge |-> !memReqValid);
endmodule

// File: rtl/mshr_dpath.sv
module mshr_dpath
  import mshr_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int WORDS     = 4,
  parameter int LINE_W    = 28,
  parameter int REG_W     = 5,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int WOFF_W   = $clog2(WORDS),
  localparam int NUM_REGS = 1 << REG_W
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  mshrStrobes_t                                 strb,
  input  logic [IDX_W-1:0]                             allocIdx,
  input  logic [IDX_W-1:0]                             mergeIdx,
  input  logic [IDX_W-1:0]                             freeIdx,
  input  logic [LINE_W-1:0]                            missLine,
  input  logic [WOFF_W-1:0]                            missWord,
  input  logic [REG_W-1:0]                             missDest,
  input  logic [WORDS-1:0][DATA_W-1:0]                 refillData,
  output logic [NUM_SLOTS-1:0]                         entValid,
  output logic [NUM_SLOTS-1:0][LINE_W-1:0]             entLine,
  output logic [NUM_SLOTS-1:0][WORDS-1:0]              slotBusy,
  output logic [NUM_REGS-1:0]                          regEmpty,
  output logic [WORDS-1:0]                             wbValid,
  output logic [WORDS-1:0][REG_W-1:0]                  wbDest,
  output logic [WORDS-1:0][DATA_W-1:0]                 wbData
);
  logic [NUM_SLOTS-1:0][WORDS-1:0][REG_W-1:0] slotDest;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      entLine  <= '0;
      slotBusy <= '0;
      slotDest <= '0;
      regEmpty <= '0;
    end else begin
      if (strb.free) begin
        entValid[freeIdx] <= 1'b0;
        slotBusy[freeIdx] <= '0;
        for (int w = 0; w < WORDS; w++) begin
          if (slotBusy[freeIdx][w]) regEmpty[slotDest[freeIdx][w]] <= 1'b0;
        end
      end
      if (strb.alloc) begin
        entValid[allocIdx]           <= 1'b1;
        entLine[allocIdx]            <= missLine;
        slotBusy[allocIdx]           <= '0;
        slotBusy[allocIdx][missWord] <= 1'b1;
        slotDest[allocIdx][missWord] <= missDest;
        regEmpty[missDest]           <= 1'b1;
      end
      if (strb.merge) begin
        slotBusy[mergeIdx][missWord] <= 1'b1;
        slotDest[mergeIdx][missWord] <= missDest;
        regEmpty[missDest]           <= 1'b1;
      end
    end
  end

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_lane
      assign wbValid[w] = strb.free && slotBusy[freeIdx][w];
      assign wbDest[w]  = slotDest[freeIdx][w];
      assign wbData[w]  = refillData[w];

      // R5: a lane only ever writes a register that is waiting.
      a_r5_lane_targets_empty: assert property (@(posedge clk) disable iff (!rstN)
        wbValid[w] |-> regEmpty[wbDest[w]]);
    end
  endgenerate

  // R12: a new slot is opened only where none is in use.
  a_r12_alloc_idle_slot: assert property (@(posedge clk) disable iff (!rstN)
    strb.alloc |-> !entValid[allocIdx]);

  // R7: no slot is opened while every slot is busy.
  a_r7_no_alloc_when_full: assert property (@(posedge clk) disable iff (!rstN)
    strb.alloc |-> !(&entValid));

  // R3: a merge lands on a busy slot holding the same line.
  a_r3_merge_same_line: assert property (@(posedge clk) disable iff (!rstN)
    strb.merge |-> entValid[mergeIdx] && (entLine[mergeIdx] == missLine));

  // R4: an accepted destination reads Empty on the next cycle.
  a_r4_dest_marked_empty: assert property (@(posedge clk) disable iff (!rstN)
    (strb.alloc || strb.merge) |=> regEmpty[$past(missDest)]);
endmodule

// File: rtl/mshr_unit.sv
module mshr_unit
  import mshr_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int WORDS     = 4,
  parameter int LINE_W    = 28,
  parameter int REG_W     = 5,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int WOFF_W   = $clog2(WORDS),
  localparam int NUM_REGS = 1 << REG_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      missValid,
  input  logic [LINE_W-1:0]         missLine,
  input  logic [WOFF_W-1:0]         missWord,
  input  logic [REG_W-1:0]          missDest,
  output logic                      missStall,
  output logic                      memReqValid,
  output logic [LINE_W-1:0]         memReqLine,
  output logic [IDX_W-1:0]          memReqTag,
  input  logic                      refillValid,
  input  logic [IDX_W-1:0]          refillTag,
  input  logic [WORDS*DATA_W-1:0]   refillData,
  output logic [WORDS-1:0]          wbValid,
  output logic [WORDS*REG_W-1:0]    wbDest,
  output logic [WORDS*DATA_W-1:0]   wbData,
  input  logic [REG_W-1:0]          qryReg,
  output logic                      qryFull
);
  mshrStrobes_t                     strb;
  logic [IDX_W-1:0]                 allocIdx, mergeIdx, freeIdx;
  logic [NUM_SLOTS-1:0]             entValid;
  logic [NUM_SLOTS-1:0][LINE_W-1:0] entLine;
  logic [NUM_SLOTS-1:0][WORDS-1:0]  slotBusy;
  logic [NUM_REGS-1:0]              regEmpty;

  mshr_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .WORDS(WORDS), .LINE_W(LINE_W), .REG_W(REG_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missLine(missLine), .missWord(missWord), .missDest(missDest),
    .refillValid(refillValid), .refillTag(refillTag),
    .entValid(entValid), .entLine(entLine), .slotBusy(slotBusy), .regEmpty(regEmpty),
    .strb(strb), .allocIdx(allocIdx), .mergeIdx(mergeIdx), .freeIdx(freeIdx),
    .missStall(missStall), .memReqValid(memReqValid), .memReqLine(memReqLine),
    .memReqTag(memReqTag)
  );

  mshr_dpath #(
    .NUM_SLOTS(NUM_SLOTS), .WORDS(WORDS), .LINE_W(LINE_W), .REG_W(REG_W), .DATA_W(DATA_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .allocIdx(allocIdx), .mergeIdx(mergeIdx), .freeIdx(freeIdx),
    .missLine(missLine), .missWord(missWord), .missDest(missDest),
    .refillData(refillData),
    .entValid(entValid), .entLine(entLine), .slotBusy(slotBusy), .regEmpty(regEmpty),
    .wbValid(wbValid), .wbDest(wbDest), .wbData(wbData)
  );

  assign qryFull = !regEmpty[qryReg];
endmodule

// File: tb/mshr_unit_bench.sv
module mshr_unit_bench;
  localparam int NS = 4, WD = 4, LW = 28, RW = 5, DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic missValid = 1'b0;
  logic [LW-1:0] missLine = '0;
  logic [1:0] missWord = '0;
  logic [RW-1:0] missDest = '0;
  logic missStall, memReqValid;
  logic [LW-1:0] memReqLine;
  logic [1:0] memReqTag;
  logic refillValid = 1'b0;
  logic [1:0] refillTag = '0;
  logic [WD*DW-1:0] refillData = '0;
  logic [WD-1:0] wbValid;
  logic [WD*RW-1:0] wbDest;
  logic [WD*DW-1:0] wbData;
  logic [RW-1:0] qryReg = '0;
  logic qryFull;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mshr_unit u_mshr_unit (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missLine(missLine), .missWord(missWord), .missDest(missDest),
    .missStall(missStall), .memReqValid(memReqValid), .memReqLine(memReqLine),
    .memReqTag(memReqTag),
    .refillValid(refillValid), .refillTag(refillTag), .refillData(refillData),
    .wbValid(wbValid), .wbDest(wbDest), .wbData(wbData),
    .qryReg(qryReg), .qryFull(qryFull)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Present one miss for one cycle; outputs sampled before the capturing edge.
  task automatic doMiss(input logic [LW-1:0] ln, input int wd, input int dst,
                        output logic stl, output logic rq, output logic [LW-1:0] rl,
                        output logic [1:0] tg);
    @(negedge clk);
    missValid = 1'b1; missLine = ln; missWord = 2'(wd); missDest = RW'(dst);
    #1;
    stl = missStall; rq = memReqValid; rl = memReqLine; tg = memReqTag;
    @(negedge clk);
    missValid = 1'b0;
  endtask

  // Present one refill, optionally together with a miss.
  task automatic doRefill(input int tag, input logic [DW-1:0] base, input bit withMiss,
                          input logic [LW-1:0] ln, input int dst,
                          output logic [WD-1:0] wv, output logic [WD*RW-1:0] wdst,
                          output logic [WD*DW-1:0] wdat, output logic stl, output logic rq);
    @(negedge clk);
    refillValid = 1'b1; refillTag = 2'(tag);
    for (int w = 0; w < WD; w++) refillData[w*DW +: DW] = base + DW'(w);
    missValid = withMiss; missLine = ln; missWord = '0; missDest = RW'(dst);
    #1;
    wv = wbValid; wdst = wbDest; wdat = wbData; stl = missStall; rq = memReqValid;
    @(negedge clk);
    refillValid = 1'b0; missValid = 1'b0;
  endtask

  task automatic qry(input int r, output logic f);
    qryReg = RW'(r);
    #1;
    f = qryFull;
  endtask

  task automatic t_reset();
    logic f;
    qry(5, f);
    chk("R1", "reg5 full after reset", f, 1);
    qry(31, f);
    chk("R1", "reg31 full after reset", f, 1);
    chk("R1", "no request at reset", memReqValid, 0);
    chk("R1", "no writeback at reset", wbValid, 0);
  endtask

  task automatic t_alloc_merge();
    logic stl, rq, f; logic [LW-1:0] rl; logic [1:0] tg;
    logic [WD-1:0] wv; logic [WD*RW-1:0] wdst; logic [WD*DW-1:0] wdat;
    doMiss(28'h100, 0, 3, stl, rq, rl, tg);
    chk("R2", "first miss not stalled", stl, 0);
    chk("R2", "first miss requests", rq, 1);
    chk("R2", "request line", rl, 28'h100);
    chk("R2", "request tag lowest idle", tg, 0);
    qry(3, f);
    chk("R4", "reg3 empty after miss", f, 0);
    doMiss(28'h100, 2, 7, stl, rq, rl, tg);
    chk("R3", "merge not stalled", stl, 0);
    chk("R3", "merge raises no request", rq, 0);
    qry(7, f);
    chk("R4", "reg7 empty after merge", f, 0);
    doMiss(28'h100, 2, 9, stl, rq, rl, tg);
    chk("R8", "same word stalled", stl, 1);
    chk("R8", "same word no request", rq, 0);
    qry(9, f);
    chk("R8", "reg9 stays full", f, 1);
    doMiss(28'h200, 1, 3, stl, rq, rl, tg);
    chk("R9", "pending destination stalled", stl, 1);
    chk("R9", "pending destination no request", rq, 0);
    doMiss(28'h200, 1, 4, stl, rq, rl, tg);
    chk("R2", "second line tag", tg, 1);
    chk("R2", "second line requests", rq, 1);
    doRefill(0, 32'hA000_0000, 1'b1, 28'h300, 12, wv, wdst, wdat, stl, rq);
    chk("R5", "lane valid mask", wv, 4'b0101);
    chk("R5", "lane0 dest", wdst[0*RW +: RW], 3);
    chk("R5", "lane2 dest", wdst[2*RW +: RW], 7);
    chk("R5", "lane0 data", wdat[0*DW +: DW], 32'hA000_0000);
    chk("R5", "lane2 data", wdat[2*DW +: DW], 32'hA000_0002);
    chk("R10", "miss during refill stalled", stl, 1);
    chk("R10", "miss during refill no request", rq, 0);
    qry(3, f);
    chk("R6", "reg3 full after refill", f, 1);
    qry(7, f);
    chk("R6", "reg7 full after refill", f, 1);
    qry(12, f);
    chk("R10", "reg12 untouched", f, 1);
    doRefill(1, 32'hB000_0000, 1'b0, '0, 0, wv, wdst, wdat, stl, rq);
    chk("R5", "second refill lane1 only", wv, 4'b0010);
    chk("R5", "lane1 data", wdat[1*DW +: DW], 32'hB000_0001);
    doMiss(28'h100, 0, 3, stl, rq, rl, tg);
    chk("R6", "released line fetched again", rq, 1);
    chk("R6", "released line gets tag 0", tg, 0);
    doRefill(0, 32'h0, 1'b0, '0, 0, wv, wdst, wdat, stl, rq);
  endtask

  task automatic t_full();
    logic stl, rq, f; logic [LW-1:0] rl; logic [1:0] tg;
    logic [WD-1:0] wv; logic [WD*RW-1:0] wdst; logic [WD*DW-1:0] wdat;
    for (int i = 0; i < NS; i++) begin
      doMiss(28'h400 + LW'(i), 0, 10 + i, stl, rq, rl, tg);
      chk("R12", "slot request issued", rq, 1);
      chk("R12", "distinct tag", tg, i);
    end
    doMiss(28'h4FF, 0, 14, stl, rq, rl, tg);
    chk("R7", "full table stalls", stl, 1);
    chk("R7", "full table no request", rq, 0);
    qry(14, f);
    chk("R7", "reg14 stays full", f, 1);
    doRefill(2, 32'hC000_0000, 1'b0, '0, 0, wv, wdst, wdat, stl, rq);
    chk("R5", "slot2 lane0 dest", wdst[0*RW +: RW], 12);
    doMiss(28'h4FF, 0, 14, stl, rq, rl, tg);
    chk("R6", "freed slot reused", tg, 2);
    chk("R6", "freed slot request", rq, 1);
    for (int i = 0; i < NS; i++) doRefill(i, 32'h0, 1'b0, '0, 0, wv, wdst, wdat, stl, rq);
    qry(14, f);
    chk("R6", "reg14 full after drain", f, 1);
  endtask

  task automatic t_idle_refill();
    logic stl, rq, f;
    logic [WD-1:0] wv; logic [WD*RW-1:0] wdst; logic [WD*DW-1:0] wdat;
    logic [LW-1:0] rl; logic [1:0] tg;
    doRefill(1, 32'hD000_0000, 1'b0, '0, 0, wv, wdst, wdat, stl, rq);
    chk("R11", "idle tag no writeback", wv, 0);
    qry(4, f);
    chk("R11", "reg4 still full", f, 1);
    doMiss(28'h500, 3, 20, stl, rq, rl, tg);
    chk("R11", "table still empty, tag 0", tg, 0);
    doRefill(0, 32'h0, 1'b0, '0, 0, wv, wdst, wdat, stl, rq);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_alloc_merge();
    t_full();
    t_idle_refill();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule